// File: doc/BRIEF.md
# Day-of-Year BCD Counter

This block holds the ordinal day of the year as three BCD digits: a single hundreds digit and a two-digit low part. Each day tick advances the count by exactly one. The low part runs through 00 to 99 and carries into the hundreds digit while that digit is 0, 1 or 2. Once the hundreds digit reaches 3, the low part stops at 65 in a common year or at 66 in a leap year. The next tick after that last day returns the count to day 001.

A calendar datapath uses the block by pulsing `day_tick` once at each midnight. It drives `leap_year` from whatever logic tracks the year. Software can preset the day through the load bus, or clear it to 001 with the synchronous clear input. The asynchronous reset is released through a two-stage synchronizer inside the block.

Top module: `doy_counter`

## Requirements
- R1: While `rst_n` is low, the outputs read day 001: `hund_o` = 0 and `lo_o` = 8'h01.
- R2: When `clr` is high at a clock edge, the count becomes 001. This takes precedence over `load` and `day_tick` in the same cycle.
- R3: When `load` is high and `clr` is low, `hund_o` takes the value of `load_hund` and `lo_o` takes the value of `load_lo`. The load wins over a coincident `day_tick`.
- R4: With `clr`, `load` and `day_tick` all low, both outputs hold their value. This holds even when `leap_year` changes.
- R5: A tick with the hundreds digit in 0..2 and the low part below 99 adds one to the low part in BCD. The ones digit is in bits [3:0] and the tens digit in bits [7:4], so 09 becomes 10.
- R6: A tick with the hundreds digit in 0..2 and the low part at 99 sets the low part to 00 and adds one to the hundreds digit.
- R7: With `leap_year` low, day 365 is the last day of the year. A tick at 365 gives 001.
- R8: With `leap_year` high, 365 advances to 366, and a tick at 366 gives 001.
- R9: A tick when the hundreds digit is 3 or more and the low part is at or above the limit for the current year type gives 001. For example, 366 with `leap_year` low gives 001.
- R10: Starting from 001, 364 ticks in a common year reach 365. In a leap year, 365 ticks reach 366.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear to day 001 |
| day_tick | input | 1 | One-cycle pulse that advances the day by one |
| leap_year | input | 1 | High when the current year has 366 days |
| load | input | 1 | Synchronous preset from the load bus |
| load_hund | input | 4 | Hundreds digit to load |
| load_lo | input | 8 | Low two BCD digits to load (tens in [7:4]) |
| hund_o | output | 4 | Hundreds digit of the day |
| lo_o | output | 8 | Low two BCD digits of the day |

## Verification
All results are registered. A clear, a load or a tick sampled at one rising edge shows on the outputs just after that same edge, and the rollover to 001 follows the same timing. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a cycle after the edge that produced them. After `rst_n` rises, the bench waits for the synchronizer to release the registers before it applies any stimulus. The counting runs compare the outputs against a day number that the bench keeps itself.

// File: rtl/doy_pkg.sv
package doy_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
  localparam bcd_digit_t BCD_NINE = 4'd9;
endpackage

// File: rtl/doy_rst_sync.sv
module doy_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/doy_bcd_inc.sv
module doy_bcd_inc
  import doy_pkg::*;
#(
  parameter int unsigned NDIG = 2,
  localparam int unsigned W = NDIG * DIGIT_W
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] nxt_o,
  output logic         carry_o
);
  // all_nine[i]: every digit below i is nine, so digit i takes the increment
  logic [NDIG:0] all_nine;
  assign all_nine[0] = 1'b1;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    bcd_digit_t d;
    logic       is9;
    assign d  = val_i[i*DIGIT_W +: DIGIT_W];
    assign is9 = (d >= BCD_NINE);
    assign all_nine[i+1] = all_nine[i] & is9;
    always_comb begin
      if (!all_nine[i])  nxt_o[i*DIGIT_W +: DIGIT_W] = d;
      else if (is9)      nxt_o[i*DIGIT_W +: DIGIT_W] = '0;
      else               nxt_o[i*DIGIT_W +: DIGIT_W] = d + 4'd1;
    end
  end

  assign carry_o = all_nine[NDIG];
endmodule

// File: rtl/doy_end_detect.sv
module doy_end_detect #(
  parameter int unsigned HUND_W     = 4,
  parameter int unsigned LO_W       = 8,
  parameter logic [HUND_W-1:0] FINAL_HUND = 4'd3,
  parameter logic [LO_W-1:0]   END_NORM   = 8'h65,
  parameter logic [LO_W-1:0]   END_LEAP   = 8'h66
) (
  input  logic [HUND_W-1:0] hund_i,
  input  logic [LO_W-1:0]   lo_i,
  input  logic              leap_i,
  output logic              last_day_o
);
  logic [LO_W-1:0] limit;
  logic            in_last_hund;
  logic            past_hund;

  // Valid BCD compares correctly as plain binary
  assign limit        = leap_i ? END_LEAP : END_NORM;
  assign in_last_hund = (hund_i == FINAL_HUND);
  assign past_hund    = (hund_i > FINAL_HUND);
  assign last_day_o   = past_hund | (in_last_hund & (lo_i >= limit));
endmodule

// File: rtl/doy_counter.sv
module doy_counter
  import doy_pkg::*;
#(
  parameter int unsigned LO_DIGITS = 2,
  parameter int unsigned HUND_W    = DIGIT_W,
  parameter logic [HUND_W-1:0] FINAL_HUND = 4'd3,
  parameter logic [LO_DIGITS*DIGIT_W-1:0] END_NORM = 8'h65,
  parameter logic [LO_DIGITS*DIGIT_W-1:0] END_LEAP = 8'h66
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          day_tick,
  input  logic                          leap_year,
  input  logic                          load,
  input  logic [HUND_W-1:0]             load_hund,
  input  logic [LO_DIGITS*DIGIT_W-1:0]  load_lo,
  output logic [HUND_W-1:0]             hund_o,
  output logic [LO_DIGITS*DIGIT_W-1:0]  lo_o
);
  localparam int unsigned LO_W = LO_DIGITS * DIGIT_W;
  localparam logic [HUND_W-1:0] FIRST_HUND = '0;
  localparam logic [LO_W-1:0]   FIRST_LO   = {{(LO_W-1){1'b0}}, 1'b1};
  localparam logic [HUND_W-1:0] HUND_ONE   = {{(HUND_W-1){1'b0}}, 1'b1};

  logic              rst_sync_n;
  logic [HUND_W-1:0] hund_q, hund_d;
  logic [LO_W-1:0]   lo_q, lo_d, lo_inc;
  logic              lo_carry;
  logic              last_day;
  logic              upd_en;

  doy_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  doy_bcd_inc #(.NDIG(LO_DIGITS)) u_inc (
    .val_i   (lo_q),
    .nxt_o   (lo_inc),
    .carry_o (lo_carry)
  );

  doy_end_detect #(
    .HUND_W     (HUND_W),
    .LO_W       (LO_W),
    .FINAL_HUND (FINAL_HUND),
    .END_NORM   (END_NORM),
    .END_LEAP   (END_LEAP)
  ) u_end (
    .hund_i     (hund_q),
    .lo_i       (lo_q),
    .leap_i     (leap_year),
    .last_day_o (last_day)
  );

  // Next-state: clear > load > tick
  always_comb begin
    hund_d = hund_q;
    lo_d   = lo_q;
    upd_en = 1'b0;
    if (clr) begin
      upd_en = 1'b1;
      hund_d = FIRST_HUND;
      lo_d   = FIRST_LO;
    end else if (load) begin
      upd_en = 1'b1;
      hund_d = load_hund;
      lo_d   = load_lo;
    end else if (day_tick) begin
      upd_en = 1'b1;
      if (last_day) begin
        hund_d = FIRST_HUND;
        lo_d   = FIRST_LO;
      end else if (lo_carry) begin
        hund_d = hund_q + HUND_ONE;
        lo_d   = lo_inc;
      end else begin
        lo_d   = lo_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hund_q <= FIRST_HUND;
      lo_q   <= FIRST_LO;
    end else if (upd_en) begin
      hund_q <= hund_d;
      lo_q   <= lo_d;
    end
  end

  assign hund_o = hund_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/doy_counter_chk.sv
module doy_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       day_tick,
  input logic       leap_year,
  input logic       load,
  input logic [3:0] load_hund,
  input logic [7:0] load_lo,
  input logic [3:0] hund_o,
  input logic [7:0] lo_o
);
  // R2
  clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hund_o == 4'd0 && lo_o == 8'h01));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (hund_o == $past(load_hund) && lo_o == $past(load_lo)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !day_tick) |=> ($stable(hund_o) && $stable(lo_o)));

  // R6
  hund_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_tick && !clr && !load && lo_o == 8'h99 && hund_o < 4'd3)
      |=> (lo_o == 8'h00 && hund_o == $past(hund_o) + 4'd1));

  // R7
  wrap_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_tick && !clr && !load && !leap_year && hund_o == 4'd3 && lo_o == 8'h65)
      |=> (hund_o == 4'd0 && lo_o == 8'h01));

  // R8
  wrap_leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (day_tick && !clr && !load && leap_year && hund_o == 4'd3 && lo_o == 8'h66)
      |=> (hund_o == 4'd0 && lo_o == 8'h01));
endmodule

bind doy_counter doy_counter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .clr       (clr),
  .day_tick  (day_tick),
  .leap_year (leap_year),
  .load      (load),
  .load_hund (load_hund),
  .load_lo   (load_lo),
  .hund_o    (hund_o),
  .lo_o      (lo_o)
);

// File: tb/doy_counter_test.sv
`timescale 1ns/1ps
module doy_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, day_tick = 1'b0, leap_year = 1'b0, load = 1'b0;
  logic [3:0] load_hund = '0;
  logic [7:0] load_lo = '0;
  logic [3:0] hund_o;
  logic [7:0] lo_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  doy_counter uut (.*);

  function automatic int to_day(input logic [3:0] h, input logic [7:0] l);
    return h * 100 + l[7:4] * 10 + l[3:0];
  endfunction

  task automatic check(input string req, input int exp_day);
    int act;
    act = to_day(hund_o, lo_o);
    checks++;
    if (act != exp_day) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_day);
    end
  endtask

  // One cycle: drive at falling edge, result readable at next falling edge
  task automatic cyc(input bit c, input bit t, input bit ld,
                     input logic [3:0] h, input logic [7:0] l);
    clr = c; day_tick = t; load = ld; load_hund = h; load_lo = l;
    @(negedge clk);
    clr = 0; day_tick = 0; load = 0;
  endtask

  task automatic preset(input logic [3:0] h, input logic [7:0] l);
    cyc(0, 0, 1, h, l);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, '0, '0);
  endtask

  task automatic t_reset;
    rst_n = 0;
    @(negedge clk);
    check("R1", 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1", 1);
  endtask

  task automatic t_bcd_step;
    leap_year = 0;
    cyc(1, 0, 0, '0, '0);
    tick_n(8);  check("R5", 9);
    tick_n(1);  check("R5", 10);
    preset(4'd2, 8'h39); tick_n(1); check("R5", 240);
  endtask

  task automatic t_carry;
    preset(4'd0, 8'h99); tick_n(1); check("R6", 100);
    preset(4'd2, 8'h99); tick_n(1); check("R6", 300);
  endtask

  task automatic t_year_end;
    leap_year = 0;
    preset(4'd3, 8'h64); tick_n(1); check("R7", 365);
    tick_n(1); check("R7", 1);
    leap_year = 1;
    preset(4'd3, 8'h65); tick_n(1); check("R8", 366);
    tick_n(1); check("R8", 1);
    preset(4'd3, 8'h66); leap_year = 0; tick_n(1); check("R9", 1);
    preset(4'd3, 8'h80); leap_year = 1; tick_n(1); check("R9", 1);
  endtask

  task automatic t_priority;
    preset(4'd1, 8'h23);
    cyc(0, 1, 1, 4'd2, 8'h50); check("R3", 250);
    cyc(1, 1, 1, 4'd3, 8'h10); check("R2", 1);
    preset(4'd1, 8'h77);
    leap_year = ~leap_year;
    repeat (4) @(negedge clk);
    check("R4", 177);
  endtask

  task automatic t_full_year(input bit lp);
    int exp_d;
    leap_year = lp;
    cyc(1, 0, 0, '0, '0);
    exp_d = 1;
    for (int i = 0; i < (lp ? 365 : 364); i++) begin
      tick_n(1);
      exp_d++;
      if (to_day(hund_o, lo_o) != exp_d) begin
        check("R10", exp_d);
        break;
      end
    end
    check("R10", lp ? 366 : 365);
    tick_n(1);
    check(lp ? "R8" : "R7", 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_bcd_step();
    t_carry();
    t_year_end();
    t_priority();
    t_full_year(0);
    t_full_year(1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule